// File: doc/BRIEF.md
# Sixteen-Pin GPIO Block with Masked Output Writes and Shared Interrupt

This block gives software control of sixteen general-purpose pins through a small word-addressed register bus. Each pin can be an input or an output. Output levels are changed by a write that carries a per-pin mask in its upper half-word. A single write can therefore set or clear any subset of pins without first reading the output register. Pin levels are sampled once per clock and can be read back from a status register.

The eight upper pins also feed one active-high, level-sensitive interrupt request. Each of these pins raises the request only while its own enable bit is set.

A control register provides a soft reset and a clock-run bit. After power-up the clock-run bit is clear, so the block ignores register writes until software enables it. The intended start-up is a write of 3 (reset with the clock running) followed by a write of 1 (run). A write of 2 parks the block in reset with its clock stopped.

Top module: `mgpio_top`

## Requirements
- R1: After rst_ni is asserted, every register reads 0, pad_oe_o and pad_o are 0 and irq_o is low. With the control register at 0 the block is stopped, so writes to the direction, output and interrupt-enable registers have no effect.
- R2: The control register is at word address 4. Bit 0 runs the clock and bit 1 holds the soft reset. It accepts writes in every state and reads back in bits 1:0.
- R3: The direction register is at word address 0. It reads back exactly the 16 bits written, and pad_oe_o equals it bit for bit (1 = output).
- R4: pad_o[n] equals output bit n when direction bit n is 1, and is 0 otherwise.
- R5: A write to the output register (word address 1) loads data bit n into output bit n only where mask bit n+16 is 1. All other output bits keep their value. The register reads back in bits 15:0.
- R6: While control bit 1 is set, starting one cycle after it is written, the direction, output and interrupt-enable registers and the pin-state register read 0, and writes to the first three are ignored.
- R7: While the block runs, the pin-state register (word address 2) returns pad_i as sampled at the previous clock edge, and writes to it have no effect.
- R8: While the block runs, irq_o is the OR over k of (pin-state bit 8+k AND enable bit k), for k from 0 to 7. Pins 0 to 7 never affect it.
- R9: The interrupt-enable register is at word address 3. It keeps bits 7:0 of a write, and bits 15:8 always read 0.
- R10: With the control register at 0, the pin-state register holds its last value, irq_o is low, and writes to the direction, output and interrupt-enable registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data; bits 31:16 are the output-write mask |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pad_i | input | 16 | Pin levels from the pads |
| pad_o | output | 16 | Pin drive values |
| pad_oe_o | output | 16 | Pin drive enables, 1 = drive |
| irq_o | output | 1 | Shared active-high interrupt from pins 8 to 15 |

## Verification
The assertions assume a single-cycle write strobe with a stable address and data around the sampling edge. They also assume that pad_i is synchronous to clk_i, so the pin-state register sees clean levels. The bench changes every input on the falling edge, drives pad_i from the same clock, and never issues back-to-back conflicting writes within one edge. The sweeps cover all 256 enable patterns, every pin under both mask polarities, and each control-register state.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_DIR  = 3'd0;
  localparam logic [ADDR_W-1:0] A_OUT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PIN  = 3'd2;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;
  localparam int CTRL_RUN = 0;
  localparam int CTRL_RST = 1;
endpackage

// File: rtl/mgpio_regs.sv
module mgpio_regs
  import mgpio_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int IRQ_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] out_o,
  output logic [IRQ_PINS-1:0] ien_o,
  output logic [1:0]          ctrl_o,
  output logic                run_o,
  output logic                soft_rst_o
);
  localparam int MASK_LO = DATA_W / 2;

  logic [1:0] ctrl_q;
  logic       active;
  logic [NUM_PINS-1:0] wmask, wval;

  assign wmask      = wdata_i[MASK_LO +: NUM_PINS];
  assign wval       = wdata_i[NUM_PINS-1:0];
  assign soft_rst_o = ctrl_q[CTRL_RST];
  assign run_o      = ctrl_q[CTRL_RUN] & ~ctrl_q[CTRL_RST];
  assign active     = run_o;
  assign ctrl_o     = ctrl_q;

  // control is writable in every state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ctrl_q <= '0;
    else if (we_i && addr_i == A_CTRL)    ctrl_q <= wdata_i[1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '0;
      ien_o <= '0;
    end else if (soft_rst_o) begin
      dir_o <= '0;
      ien_o <= '0;
    end else if (active && we_i) begin
      if (addr_i == A_DIR) dir_o <= wval;
      if (addr_i == A_IEN) ien_o <= wval[IRQ_PINS-1:0];
    end
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         out_o[n] <= 1'b0;
      else if (soft_rst_o)                                 out_o[n] <= 1'b0;
      else if (active && we_i && addr_i == A_OUT && wmask[n]) out_o[n] <= wval[n];
    end
  end

  AST_SOFT_RST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (dir_o == '0 && out_o == '0 && ien_o == '0)); // R6

  AST_MASK_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_OUT && active) |=>
      (((out_o ^ $past(out_o)) & ~$past(wdata_i[MASK_LO +: NUM_PINS])) == '0)); // R5

  AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q == 2'b00) |=> ($stable(dir_o) && $stable(out_o) && $stable(ien_o))); // R10
endmodule

// File: rtl/mgpio_sampler.sv
module mgpio_sampler #(
  parameter int NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                soft_rst_i,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pin_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pin_o <= '0;
    else if (soft_rst_i) pin_o <= '0;
    else if (run_i)      pin_o <= pad_i;
  end

  AST_PIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !soft_rst_i) |=> $stable(pin_o)); // R10

  AST_PIN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (pin_o == '0)); // R6
endmodule

// File: rtl/mgpio_irq.sv
module mgpio_irq #(
  parameter int IRQ_PINS = 8
) (
  input  logic                run_i,
  input  logic [IRQ_PINS-1:0] pin_i,
  input  logic [IRQ_PINS-1:0] ien_i,
  output logic                irq_o
);
  logic [IRQ_PINS-1:0] hit;

  for (genvar k = 0; k < IRQ_PINS; k++) begin : g_and
    assign hit[k] = pin_i[k] & ien_i[k];
  end

  assign irq_o = run_i & (|hit);
endmodule

// File: rtl/mgpio_top.sv
module mgpio_top
  import mgpio_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int IRQ_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_o
);
  localparam int IRQ_LO = NUM_PINS - IRQ_PINS;

  logic [NUM_PINS-1:0] dir_q, out_q, pin_q;
  logic [IRQ_PINS-1:0] ien_q;
  logic [1:0]          ctrl_q;
  logic                run, soft_rst;

  mgpio_regs #(.NUM_PINS(NUM_PINS), .IRQ_PINS(IRQ_PINS)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .dir_o(dir_q), .out_o(out_q), .ien_o(ien_q), .ctrl_o(ctrl_q),
    .run_o(run), .soft_rst_o(soft_rst)
  );

  mgpio_sampler #(.NUM_PINS(NUM_PINS)) u_samp (
    .clk_i, .rst_ni, .run_i(run), .soft_rst_i(soft_rst), .pad_i, .pin_o(pin_q)
  );

  mgpio_irq #(.IRQ_PINS(IRQ_PINS)) u_irq (
    .run_i(run), .pin_i(pin_q[NUM_PINS-1:IRQ_LO]), .ien_i(ien_q), .irq_o
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pad
    assign pad_oe_o[n] = dir_q[n];
    assign pad_o[n]    = dir_q[n] & out_q[n];
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_DIR:   rdata_o[NUM_PINS-1:0] = dir_q;
      A_OUT:   rdata_o[NUM_PINS-1:0] = out_q;
      A_PIN:   rdata_o[NUM_PINS-1:0] = pin_q;
      A_IEN:   rdata_o[IRQ_PINS-1:0] = ien_q;
      A_CTRL:  rdata_o[1:0]          = ctrl_q;
      default: rdata_o = '0;
    endcase
  end

  AST_IRQ_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctrl_q == 2'b01 && ien_q != '0)); // R8

  AST_OE_OFF_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_o & ~pad_oe_o) == '0)); // R4
endmodule

// File: tb/tb_mgpio_top.sv
module tb_mgpio_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  mgpio_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_out, dir_pat, data, mask;
    logic        exp_irq;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) rd_chk("R1 reset read", 3'(a), 32'h0);
    chk("R1 oe", {16'h0, pad_oe}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    // R1 block inert before enable
    wr(3'd0, 32'hFFFF);
    wr(3'd3, 32'hFF);
    @(negedge clk);
    rd_chk("R1 dir before enable", 3'd0, 32'h0);
    rd_chk("R1 ien before enable", 3'd3, 32'h0);

    // R2 start-up sequence, readback
    wr(3'd4, 32'h3);
    rd_chk("R2 ctrl=3", 3'd4, 32'h3);
    wr(3'd0, 32'h1234); // R6 ignored while in reset
    @(negedge clk);
    rd_chk("R6 dir write in reset", 3'd0, 32'h0);
    wr(3'd4, 32'h1);
    rd_chk("R2 ctrl=1", 3'd4, 32'h1);

    // R3 direction readback and oe
    for (int i = 0; i < 16; i++) begin
      dir_pat = (16'h1 << i) ^ 16'h0F0F ^ 16'(i * 16'h1111);
      wr(3'd0, {16'hFFFF, dir_pat});
      rd_chk("R3 dir readback", 3'd0, {16'h0, dir_pat});
      chk("R3 pad_oe", {16'h0, pad_oe}, {16'h0, dir_pat});
    end

    // R5/R4 masked output writes, every pin, both values
    dir_pat = 16'h5A5A;
    wr(3'd0, {16'h0, dir_pat});
    wr(3'd1, 32'hFFFF_0000);
    exp_out = 16'h0;
    for (int i = 0; i < 16; i++) begin
      for (int v = 0; v < 2; v++) begin
        mask = 16'h1 << i;
        data = 16'hA5C3 ^ 16'(i * 16'h0707);
        data[i] = v[0];
        wr(3'd1, {mask, data});
        exp_out = (exp_out & ~mask) | (data & mask);
        rd_chk("R5 single-pin masked write", 3'd1, {16'h0, exp_out});
        chk("R4 pad_o", {16'h0, pad_out}, {16'h0, exp_out & dir_pat});
      end
    end
    for (int k = 0; k < 8; k++) begin
      mask = 16'hC381 ^ 16'(k * 16'h2491);
      data = 16'h6E1B ^ 16'(k * 16'h1357);
      wr(3'd1, {mask, data});
      exp_out = (exp_out & ~mask) | (data & mask);
      rd_chk("R5 multi-pin masked write", 3'd1, {16'h0, exp_out});
    end
    wr(3'd0, 32'hFFFF);
    chk("R4 pad_o all out", {16'h0, pad_out}, {16'h0, exp_out});
    wr(3'd0, 32'h0);
    chk("R4 pad_o all in", {16'h0, pad_out}, 32'h0);

    // R7 pin-state sampling; write ignored
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      pad_in = 16'(i * 16'h3B1D) ^ 16'h8421;
      @(negedge clk);
      rd_chk("R7 pin state", 3'd2, {16'h0, pad_in});
    end
    wr(3'd2, 32'hFFFF_FFFF);
    rd_chk("R7 pin write ignored", 3'd2, {16'h0, pad_in});

    // R9 enable register width
    wr(3'd3, 32'hFFFF);
    rd_chk("R9 ien upper bits", 3'd3, 32'hFF);

    // R8 exhaustive enable sweep over several pad patterns
    for (int e = 0; e < 256; e++) begin
      wr(3'd3, {16'hFFFF, 8'hA5, 8'(e)});
      for (int p = 0; p < 10; p++) begin
        pad_in = (p < 8) ? 16'((16'h100 << p) | 16'h00FF) : ((p == 8) ? 16'h00FF : 16'hFF00);
        @(negedge clk);
        exp_irq = |(pad_in[15:8] & 8'(e));
        chk("R8 shared irq", {31'h0, irq}, {31'h0, exp_irq});
      end
    end

    // R10 clock stopped: hold and gate
    wr(3'd3, 32'hFF);
    pad_in = 16'hF00F;
    @(negedge clk);
    chk("R8 irq before stop", {31'h0, irq}, 32'h1);
    wr(3'd4, 32'h0);
    pad_in = 16'h0FF0;
    @(negedge clk);
    @(negedge clk);
    rd_chk("R10 pin holds", 3'd2, 32'hF00F);
    chk("R10 irq gated", {31'h0, irq}, 32'h0);
    wr(3'd0, 32'hBEEF);
    rd_chk("R10 dir write ignored", 3'd0, 32'h0);
    rd_chk("R10 ien kept", 3'd3, 32'hFF);

    // R6 low-power reset, then restart
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd4, 32'h1);
    wr(3'd0, 32'hFFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd4, 32'h2);
    @(negedge clk);
    rd_chk("R6 dir cleared", 3'd0, 32'h0);
    rd_chk("R6 out cleared", 3'd1, 32'h0);
    rd_chk("R6 ien cleared", 3'd3, 32'h0);
    rd_chk("R6 pin cleared", 3'd2, 32'h0);
    chk("R6 irq low", {31'h0, irq}, 32'h0);
    rd_chk("R2 ctrl=2", 3'd4, 32'h2);
    wr(3'd4, 32'h3);
    wr(3'd4, 32'h1);
    wr(3'd0, 32'h00C3);
    rd_chk("R2 restart works", 3'd0, 32'hC3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule